// File: doc/BRIEF.md
# Serial Frame Receiver with Stop-Bit Checking

This block recovers 8-bit characters from an asynchronous serial line. A free-running oversample tick, sixteen per bit time, paces a small state machine that finds the falling edge of a start bit, confirms it at mid-bit, shifts in eight data bits least significant first and then inspects the stop bit. Each finished character is copied into a holding register together with a full flag. A stop bit sampled low raises a frame-error flag in the same update. An all-zero line, the break condition, therefore arrives as a frame error with a byte of 00h. Any other byte with the error flag set marks a corrupted frame.

Software-side access uses two plain strobes. A status read followed by a data read retires the character and clears both flags. The full flag acts as the valid signal. The status-then-data pair acts as the ready handshake. There is no back-pressure toward the line: a character that completes while the previous one is still held replaces it. The interrupt request follows the full flag under an enable input. The error flag never requests an interrupt of its own.

Top module: `serial_rx_frame`

## Requirements
- R1: After reset, rx_data is 00h and rx_full, frame_err and irq are all 0.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, and a stop bit, each lasting 16 ticks. On completion the byte is placed on rx_data and rx_full is set. rx_data changes only when a frame completes.
- R3: A start bit is accepted only if the line is still low at the eighth tick after the falling edge is seen. A shorter low pulse produces no frame.
- R4: If the stop bit is sampled low, frame_err is set in the same cycle as rx_full, and the received byte is still stored. frame_err is never 1 while rx_full is 0.
- R5: A break, meaning the line held low for the whole frame, yields frame_err = 1 with rx_data = 00h.
- R6: After a frame error the receiver does not look for a new start bit until the line has returned high. A line that stays low produces no further frames.
- R7: A status read (rd_status) followed later by a data read (rd_data) clears rx_full and frame_err. A data read without a preceding status read, or a status read alone, leaves both flags set. Any data read uses up a pending status read.
- R8: irq equals rx_full AND irq_en. frame_err alone never drives irq.
- R9: When a frame completes in the same cycle as a clearing data read, the new frame wins: rx_full is 1, rx_data holds the new byte, and frame_err reflects the new stop bit.
- R10: With os_tick high every cycle and two synchronizer stages, rx_full rises on the 155th rising clock edge after the first edge that sees rx_in low (edge 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rd_status | input | 1 | Status read strobe, one cycle |
| rd_data | input | 1 | Data read strobe, one cycle |
| irq_en | input | 1 | Receive interrupt enable |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Receive data full flag |
| frame_err | output | 1 | Stop bit was sampled low |
| irq | output | 1 | Receive interrupt request |

## Verification
The load of a finished character and the clearing data read can land in the same clock cycle. The bench sets this up by leaving a character unretired and issuing a status read during the next frame. It then raises rd_data exactly in the cycle before the edge where the latency rule of R10 says the flags update. The outcome passes only if the new byte and its stop-bit status remain, with rx_full still set. A later lone data read must also leave the flags untouched, which shows the pending status read was used up.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_HOLD
  } rx_state_e;
endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serrx_deser.sv
module serrx_deser
  import serrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  output logic             done,
  output logic [DBITS-1:0] byte_o,
  output logic             stop_bad
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam int HALF = OSR / 2;

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DBITS-1:0]  shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      byte_o   <= '0;
      stop_bad <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rx ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt   <= '0;
              shreg <= {rx, shreg[DBITS-1:1]};
              if (bitn == BW'(DBITS - 1)) state <= S_STOP;
              else                        bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt      <= '0;
              done     <= 1'b1;
              byte_o   <= shreg;
              stop_bad <= !rx;
              state    <= rx ? S_IDLE : S_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HOLD: begin
            if (rx) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_until_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !rx) |=> (state == S_HOLD));

  p_err_enters_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_bad) |-> (state == S_HOLD));
endmodule

// File: rtl/serrx_regs.sv
module serrx_regs #(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DBITS-1:0] load_byte,
  input  logic             load_fe,
  input  logic             rd_status,
  input  logic             rd_data,
  input  logic             irq_en,
  output logic [DBITS-1:0] data_q,
  output logic             full,
  output logic             fe,
  output logic             irq
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      full   <= 1'b0;
      fe     <= 1'b0;
      armed  <= 1'b0;
    end else if (load) begin
      data_q <= load_byte;
      full   <= 1'b1;
      fe     <= load_fe;
      armed  <= 1'b0;
    end else if (rd_data) begin
      if (armed) begin
        full <= 1'b0;
        fe   <= 1'b0;
      end
      armed <= 1'b0;
    end else if (rd_status) begin
      armed <= full | fe;
    end
  end

  assign irq = full & irq_en;

  p_fe_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fe |-> full);

  p_clear_by_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(rd_data));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full && data_q == $past(load_byte) && fe == $past(load_fe)));

  p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(data_q));

  p_no_err_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !irq_en) |-> !irq);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame #(
  parameter int OSR         = 16,
  parameter int DBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rx_in,
  input  logic             rd_status,
  input  logic             rd_data,
  input  logic             irq_en,
  output logic [DBITS-1:0] rx_data,
  output logic             rx_full,
  output logic             frame_err,
  output logic             irq
);
  logic             rx_s;
  logic             done;
  logic [DBITS-1:0] byte_w;
  logic             stop_bad;

  serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_in),
    .q     (rx_s)
  );

  serrx_deser #(.OSR(OSR), .DBITS(DBITS)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .rx       (rx_s),
    .done     (done),
    .byte_o   (byte_w),
    .stop_bad (stop_bad)
  );

  serrx_regs #(.DBITS(DBITS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done),
    .load_byte (byte_w),
    .load_fe   (stop_bad),
    .rd_status (rd_status),
    .rd_data   (rd_data),
    .irq_en    (irq_en),
    .data_q    (rx_data),
    .full      (rx_full),
    .fe        (frame_err),
    .irq       (irq)
  );

  p_break_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_bad && byte_w == '0) |=> (frame_err && rx_data == '0));
endmodule

// File: tb/serial_rx_frame_tb.sv
module serial_rx_frame_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rx_in;
  logic       rd_status;
  logic       rd_data;
  logic       irq_en;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       frame_err;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_rx_frame dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .rd_status(rd_status), .rd_data(rd_data), .irq_en(irq_en),
    .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_fe(input bit stop_hi);
    return !stop_hi;
  endfunction

  function automatic bit exp_irq(input bit full, input bit en);
    return full & en;
  endfunction

  // drive one 160-cycle frame; optional clearing read at cycle 155, optional latency check
  task automatic send_frame(input logic [7:0] b, input bit stop_hi, input bit coll, input bit lat);
    for (int c = 0; c < 160; c++) begin
      @(negedge clk);
      if (lat && c == 155) chk(rx_full == 1'b0, "R10 before edge 155", rx_full, 0);
      if (lat && c == 156) chk(rx_full == 1'b1, "R10 at edge 155", rx_full, 1);
      if (c < 16)       rx_in = 1'b0;
      else if (c < 144) rx_in = b[(c-16)/16];
      else              rx_in = stop_hi;
      rd_data = coll && (c == 155);
    end
    @(negedge clk);
    rx_in   = 1'b1;
    rd_data = 1'b0;
  endtask

  task automatic status_then_data();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0; rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_status();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    bit sh, en;
    void'($urandom(32'h5EED1));
    rst_n = 0; os_tick = 1; rx_in = 1; rd_status = 0; rd_data = 0; irq_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rx_data == 8'h00, "R1 data", rx_data, 0);
    chk(rx_full == 1'b0, "R1 full", rx_full, 0);
    chk(frame_err == 1'b0, "R1 fe", frame_err, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R10 latency and R2 directed frame
    idle(5);
    send_frame(8'hA5, 1, 0, 1);
    chk(rx_data == 8'hA5, "R2 data A5", rx_data, 8'hA5);
    chk(frame_err == 1'b0, "R4 good stop", frame_err, 0);

    // R7 lone reads do nothing
    pulse_data();
    chk(rx_full == 1'b1, "R7 data read alone", rx_full, 1);
    pulse_status();
    idle(3);
    chk(rx_full == 1'b1, "R7 status read alone", rx_full, 1);
    pulse_data();
    chk(rx_full == 1'b0, "R7 status then data clears", rx_full, 0);

    // R3 short low glitch
    idle(5);
    @(negedge clk); rx_in = 0;
    idle(3);
    @(negedge clk); rx_in = 1;
    idle(200);
    chk(rx_full == 1'b0, "R3 glitch rejected", rx_full, 0);

    // random frames (R2, R4, R8, R7)
    for (int i = 0; i < 24; i++) begin
      b  = 8'($urandom);
      sh = ($urandom % 4) != 0;
      en = 1'($urandom);
      irq_en = en;
      idle(1 + ($urandom % 6));
      send_frame(b, sh, 0, 0);
      chk(rx_data == b, "R2 random data", rx_data, b);
      chk(rx_full == 1'b1, "R2 full set", rx_full, 1);
      chk(frame_err == exp_fe(sh), "R4 stop check", frame_err, exp_fe(sh));
      chk(irq == exp_irq(1'b1, en), "R8 irq", irq, exp_irq(1'b1, en));
      status_then_data();
      chk(rx_full == 1'b0 && frame_err == 1'b0, "R7 cleared", {rx_full, frame_err}, 0);
      chk(irq == 1'b0, "R8 irq after clear", irq, 0);
    end

    // R5 break and R6 wait for high
    irq_en = 0;
    idle(4);
    for (int c = 0; c < 260; c++) begin
      @(negedge clk); rx_in = 0;
      if (c == 170) begin
        chk(rx_full == 1'b1 && frame_err == 1'b1, "R5 break flags", {rx_full, frame_err}, 3);
        chk(rx_data == 8'h00, "R5 break data", rx_data, 0);
        chk(irq == 1'b0, "R8 error gives no irq", irq, 0);
        rd_status = 1;
      end else if (c == 171) begin
        rd_status = 0; rd_data = 1;
      end else begin
        rd_status = 0; rd_data = 0;
      end
    end
    chk(rx_full == 1'b0, "R6 no frame while line low", rx_full, 0);
    @(negedge clk); rx_in = 1;
    idle(20);
    send_frame(8'h3C, 1, 0, 0);
    chk(rx_data == 8'h3C, "R6 resume after high", rx_data, 8'h3C);

    // R9 load versus clearing read
    pulse_status();
    send_frame(8'hE7, 0, 1, 0);
    chk(rx_full == 1'b1, "R9 full kept", rx_full, 1);
    chk(rx_data == 8'hE7, "R9 new byte", rx_data, 8'hE7);
    chk(frame_err == 1'b1, "R9 new error", frame_err, 1);
    pulse_data();
    chk(rx_full == 1'b1, "R9 status read consumed", rx_full, 1);
    status_then_data();
    chk(rx_full == 1'b0, "R7 final clear", rx_full, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule